// File: doc/BRIEF.md
# Suffix-Implication Sequence Monitor

This block is a synthesizable watchdog for one fixed temporal property, meant to sit beside a design under emulation. Four single-bit conditions are sampled on every rising clock edge. Whenever the first trigger condition is seen and the second trigger condition follows on the very next edge, the monitor opens an obligation. The obligation requires the first response condition to hold on that same edge and the second response condition to hold on the following edge. If either part is missing, the monitor raises a one-cycle pulse on `fail`.

Triggers are recognised every time they happen, including back-to-back and overlapping occurrences. Each open obligation is tracked as its own activity bit, so two obligations that are alive at once are judged independently. The transitions are guarded directly by the individual input bits. No combined symbol alphabet is built from the inputs.

Top module: `seq_impl_checker`

## Requirements
- R1: While `rst` is high on a clock edge, `fail` reads 0 after that edge and every obligation and trigger history is cleared. A trigger therefore needs `ante_a` sampled high on an edge where `rst` is low.
- R2: An obligation opens on every edge where `ante_b` is high and `ante_a` was high on the previous non-reset edge. Repeats are not suppressed: holding both high opens one obligation per edge.
- R3: If an obligation opens on an edge where `cons_a` is low, `fail` is 1 during the cycle that follows that edge.
- R4: If an obligation opens with `cons_a` high and `cons_b` is low on the next edge, `fail` is 1 during the cycle that follows that next edge.
- R5: An obligation with `cons_a` high on its opening edge and `cons_b` high on the next edge produces no pulse on `fail`.
- R6: With no open obligation, `fail` stays 0 whatever `cons_a` and `cons_b` do.
- R7: Overlapping obligations are judged independently, so `fail` may be 1 on consecutive cycles, one cycle for each violated obligation.
- R8: `ante_b` high without `ante_a` high on the previous edge opens nothing.
- R9: Each obligation is flagged at most once. After a failure, continued absence of `cons_a` or `cons_b` raises no further pulse for that obligation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ante_a | input | 1 | First trigger condition |
| ante_b | input | 1 | Second trigger condition, checked one edge after `ante_a` |
| cons_a | input | 1 | First response condition, required on the trigger-completing edge |
| cons_b | input | 1 | Second response condition, required one edge later |
| fail | output | 1 | Registered one-cycle violation pulse |

## Verification
The state consists of only three bits, and an obligation lives for at most two edges, so any corrupted state shows up at `fail` within two cycles of the input that should have set or cleared it. A trigger-history bit stuck high would produce pulses after a lone `ante_b`. A lost pending bit would silently drop an R4 violation. A pending bit that fails to clear would repeat a pulse and break R9. The scoreboard compares `fail` on every cycle against a queue-based model, so a discrepancy is reported on the exact cycle it appears.

// File: rtl/seq_impl_pkg.sv
package seq_impl_pkg;

    // Registered monitor state: trigger history, pending response, pulse.
    typedef struct packed {
        logic ante_seen;   // ante_a sampled high on the previous edge
        logic pend_b;      // an obligation awaits cons_b on this edge
        logic fail;        // violation pulse
    } mon_state_t;

    localparam mon_state_t MON_RESET = '0;

endpackage

// File: rtl/seq_ante_match.sv
// Trigger recogniser: completes on every edge where the second trigger
// condition follows a first-trigger edge, with no suppression of repeats.
module seq_ante_match (
    input  logic ante_seen_q,
    input  logic ante_b,
    output logic start
);
    always_comb begin
        start = ante_seen_q & ante_b;
    end
endmodule

// File: rtl/seq_obl_eval.sv
// Response evaluator: each open obligation is an independent activity bit,
// guarded directly by the individual response inputs.
module seq_obl_eval (
    input  logic start,
    input  logic pend_q,
    input  logic cons_a,
    input  logic cons_b,
    output logic pend_d,
    output logic fail_d
);
    logic miss_first;
    logic miss_second;

    always_comb begin
        miss_first  = start & ~cons_a;
        miss_second = pend_q & ~cons_b;
        pend_d      = start & cons_a;
        fail_d      = miss_first | miss_second;
    end
endmodule

// File: rtl/seq_impl_checker.sv
module seq_impl_checker
    import seq_impl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ante_a,
    input  logic ante_b,
    input  logic cons_a,
    input  logic cons_b,
    output logic fail
);
    mon_state_t state_d;
    mon_state_t state_q;

    logic start;
    logic pend_nxt;
    logic fail_nxt;

    seq_ante_match u_ante (
        .ante_seen_q (state_q.ante_seen),
        .ante_b      (ante_b),
        .start       (start)
    );

    seq_obl_eval u_obl (
        .start  (start),
        .pend_q (state_q.pend_b),
        .cons_a (cons_a),
        .cons_b (cons_b),
        .pend_d (pend_nxt),
        .fail_d (fail_nxt)
    );

    always_comb begin
        state_d           = state_q;
        state_d.ante_seen = ante_a;
        state_d.pend_b    = pend_nxt;
        state_d.fail      = fail_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MON_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign fail = state_q.fail;

endmodule

// File: rtl/seq_impl_checker_sva.sv
module seq_impl_checker_sva (
    input logic clk,
    input logic rst,
    input logic ante_a,
    input logic ante_b,
    input logic cons_a,
    input logic cons_b,
    input logic fail
);
    // Port-level model of the trigger history and the pending response.
    logic prev_a_c;
    logic pend_c;
    logic start_c;

    assign start_c = prev_a_c & ante_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a_c <= 1'b0;
            pend_c   <= 1'b0;
        end else begin
            prev_a_c <= ante_a;
            pend_c   <= start_c & cons_a;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !fail);

    // R3
    a_r3_first_missing: assert property (@(posedge clk) disable iff (rst)
        (start_c && !cons_a) |=> fail);

    // R4
    a_r4_second_missing: assert property (@(posedge clk) disable iff (rst)
        (pend_c && !cons_b) |=> fail);

    // R6, R8
    a_r6_no_cause: assert property (@(posedge clk) disable iff (rst)
        !((start_c && !cons_a) || (pend_c && !cons_b)) |=> !fail);

endmodule

bind seq_impl_checker seq_impl_checker_sva u_sva (
    .clk    (clk),
    .rst    (rst),
    .ante_a (ante_a),
    .ante_b (ante_b),
    .cons_a (cons_a),
    .cons_b (cons_b),
    .fail   (fail)
);

// File: tb/seq_impl_checker_test.sv
`timescale 1ns/1ps
module seq_impl_checker_test;

    typedef struct {
        bit    exp;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ante_a = 1'b0;
    logic ante_b = 1'b0;
    logic cons_a = 1'b0;
    logic cons_b = 1'b0;
    logic fail;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    exp_item_t sb_q[$];
    int        obl_q[$];   // pending obligations awaiting cons_b
    bit        m_prev_a = 0;

    always #10 clk = ~clk;

    seq_impl_checker uut (
        .clk    (clk),
        .rst    (rst),
        .ante_a (ante_a),
        .ante_b (ante_b),
        .cons_a (cons_a),
        .cons_b (cons_b),
        .fail   (fail)
    );

    // Driver: applies one cycle of stimulus and pushes the expected pulse.
    task automatic step(input bit r, input bit a, input bit b,
                        input bit c, input bit d, input string tag);
        exp_item_t it;
        bit e;
        @(negedge clk);
        rst = r; ante_a = a; ante_b = b; cons_a = c; cons_b = d;
        e = 0;
        if (r) begin
            m_prev_a = 0;
            obl_q.delete();
        end else begin
            while (obl_q.size() > 0) begin
                void'(obl_q.pop_front());
                if (!d) e = 1;
            end
            if (m_prev_a && b) begin
                if (!c) e = 1;
                else obl_q.push_back(1);
            end
            m_prev_a = a;
        end
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares each registered result shortly after its edge.
    always @(posedge clk) begin
        exp_item_t it;
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            compared++;
            if (fail !== it.exp) begin
                mismatched++;
                $display("FAIL %s: fail=%b expected=%b at %0t", it.tag, fail, it.exp, $time);
            end
        end
    end

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1, tag);
    endtask

    initial begin
        // R1: reset with ante_a high, then ante_b right after release
        step(1, 1, 0, 0, 0, "R1");
        step(1, 1, 1, 0, 0, "R1");
        step(0, 0, 1, 0, 0, "R1");
        idle(2, "R1");
        // R3: missing first response
        step(0, 1, 0, 1, 1, "R3");
        step(0, 0, 1, 0, 1, "R3");
        idle(2, "R3");
        // R4: missing second response
        step(0, 1, 0, 0, 0, "R4");
        step(0, 0, 1, 1, 1, "R4");
        step(0, 0, 0, 0, 0, "R4");
        idle(2, "R4");
        // R5: complete response
        step(0, 1, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 0, "R5");
        step(0, 0, 0, 0, 1, "R5");
        idle(2, "R5");
        // R6: responses absent with no trigger
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R6");
        // R8: ante_b alone, and ante_a two edges before ante_b
        step(0, 0, 1, 0, 0, "R8");
        step(0, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        idle(2, "R8");
        // R9: one pulse, responses keep missing afterwards
        step(0, 1, 0, 1, 1, "R9");
        step(0, 0, 1, 1, 1, "R9");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R9");
        // R2/R7: both triggers held high, overlapping obligations
        step(0, 1, 1, 1, 1, "R2");
        for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 0, "R7");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 1, "R7");
        idle(3, "R7");
        // R2: random traffic, with an occasional reset (R1)
        for (int i = 0; i < 3000; i++) begin
            bit r;
            r = ($urandom_range(0, 199) == 0);
            step(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), r ? "R1" : "R2");
        end
        idle(3, "R2");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule